// File: doc/BRIEF.md
# Bypassable Instruction Tag Queue with Thread Squash

This block sits between two stages of a multithreaded in-order core and holds a short ordered list of instruction tags. Each tag is a thread number plus a 16-bit sequence number. For each arriving instruction it decides in the same cycle whether the instruction can go straight to the stage two positions downstream, skipping the queue and the next stage. If it cannot, it gives a reason code, and the surrounding control then schedules an insert in the next stage and a removal in the stage after that.

The queue takes inserts at its tail. The head is always visible on the peek outputs and can be popped. A remove request can delete an entry identified by its tag from any position. A squash, given a thread and a sequence number, deletes every younger entry of that thread. The queue closes the gaps in the same cycle and keeps the survivors in their order. Within one cycle the operations apply in a fixed order: squash, then remove, then pop, then insert. A counter records how many instructions took the bypass.

Top module: `tagq_bypass_buf`

## Requirements
- R1: `byp_go` is high in the same cycle exactly when `arr_valid` is high, the queue holds zero entries, `fwd_blocked[arr_tid]` is low and `fwd_free` is non-zero.
- R2: `byp_why` is a combinational reason code. It is 0 when `arr_valid` is low or the bypass is taken. It is 1 when the queue is not empty, 2 when the downstream stage is blocked for that thread, and 3 when the downstream stage has no free slot. The codes are checked in that priority order. `byp_sched` is high when `arr_valid` is high and `byp_go` is low.
- R3: `byp_count` resets to 0 and rises by one (wrapping at its width) in the cycle after each cycle in which `byp_go` is high.
- R4: An insert is accepted only when the occupancy, after that cycle's squash, remove and pop, is below `DEPTH`. In the next cycle `ins_done` pulses, and `ins_ok` shows acceptance. A rejected insert leaves the contents unchanged.
- R5: Accepted inserts join at the tail. `head_valid`/`head_tid`/`head_seq` show the oldest entry without removing it. `pop_valid` discards that entry.
- R6: A remove deletes the oldest stored entry whose thread and sequence number both equal `rm_tid`/`rm_seq`, wherever it sits.
- R7: A squash deletes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq`, compared as unsigned 16-bit values. Entries of other threads, and entries with an equal or smaller number, stay.
- R8: After any deletion the surviving entries keep their relative order and are packed toward the head within the same cycle. `occupancy` never exceeds `DEPTH`.
- R9: In one cycle the order is squash, then remove, then pop, then insert. A remove or pop only sees entries that survived the earlier steps.
- R10: `err` pulses for one cycle, in the cycle after a remove that finds no match or a pop that finds no entry. That failed operation changes nothing.
- R11: After reset the queue is empty, `byp_count` is 0, and `ins_done`, `ins_ok` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arr_valid | input | 1 | An instruction asks for the bypass decision |
| arr_tid | input | TID_W | Thread of the arriving instruction |
| fwd_blocked | input | 2**TID_W | Per-thread block flags of the stage two positions ahead |
| fwd_free | input | FREE_W | Free slots in that stage's incoming buffer |
| byp_go | output | 1 | Bypass taken this cycle |
| byp_sched | output | 1 | Instruction must be queued instead |
| byp_why | output | 2 | Reason code for a refused bypass |
| byp_count | output | BCNT_W | Number of bypasses taken |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of the tag to insert |
| ins_seq | input | SEQ_W | Sequence number of the tag to insert |
| ins_done | output | 1 | Insert request completed (one cycle later) |
| ins_ok | output | 1 | Completed insert was accepted |
| pop_valid | input | 1 | Discard the head entry |
| rm_valid | input | 1 | Remove the entry matching the given tag |
| rm_tid | input | TID_W | Thread of the tag to remove |
| rm_seq | input | SEQ_W | Sequence number of the tag to remove |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Entries above this number are squashed |
| head_valid | output | 1 | Queue not empty |
| head_tid | output | TID_W | Thread of the head entry |
| head_seq | output | SEQ_W | Sequence number of the head entry |
| occupancy | output | CNT_W | Number of stored entries |
| err | output | 1 | Failed pop or remove in the previous cycle |

## Verification
The bench targets insert at full capacity together with a squash in the same cycle. A design that tests capacity before applying the squash rejects an insert that should be accepted. It removes an entry from the middle and then pops the rest one by one. A design that fails to close the gap, or that reorders entries, returns the wrong head sequence. Squashes mix threads and include sequence numbers equal to the boundary and near 16'hFFFF. An off-by-one or signed compare deletes the boundary entry, or keeps entries it should delete. The bench also drives each bypass-refusal cause alone and in combination, to expose a wrong priority or a bypass granted while entries are still queued.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  typedef enum logic [1:0] {
    WHY_NONE    = 2'd0,
    WHY_QUEUED  = 2'd1,
    WHY_BLOCKED = 2'd2,
    WHY_NOROOM  = 2'd3
  } byp_why_e;
endpackage

// File: rtl/tagq_bypass_judge.sv
module tagq_bypass_judge
  import tagq_pkg::*;
#(
  parameter int TID_W  = 2,
  parameter int FREE_W = 3,
  localparam int NTHR  = 1 << TID_W
) (
  input  logic              arr_valid,
  input  logic [TID_W-1:0]  arr_tid,
  input  logic              buf_empty,
  input  logic [NTHR-1:0]   fwd_blocked,
  input  logic [FREE_W-1:0] fwd_free,
  output logic              go,
  output logic              sched,
  output byp_why_e          why
);
  always_comb begin
    why = WHY_NONE;
    if (arr_valid) begin
      if (!buf_empty)                 why = WHY_QUEUED;
      else if (fwd_blocked[arr_tid])  why = WHY_BLOCKED;
      else if (fwd_free == '0)        why = WHY_NOROOM;
    end
    go    = arr_valid && (why == WHY_NONE);
    sched = arr_valid && !go;
  end
endmodule

// File: rtl/tagq_kill_mask.sv
module tagq_kill_mask #(
  parameter int DEPTH = 4,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16
) (
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0][TID_W-1:0] ent_tid,
  input  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq,
  input  logic                        sq_valid,
  input  logic [TID_W-1:0]            sq_tid,
  input  logic [SEQ_W-1:0]            sq_seq,
  input  logic                        rm_valid,
  input  logic [TID_W-1:0]            rm_tid,
  input  logic [SEQ_W-1:0]            rm_seq,
  input  logic                        pop_valid,
  output logic [DEPTH-1:0]            keep,
  output logic                        err
);
  logic [DEPTH-1:0] surv_sq, surv_rm, rm_hit, pop_hit;
  logic             rm_found, head_seen;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      surv_sq[i] = ent_vld[i] &&
                   !(sq_valid && ent_tid[i] == sq_tid && ent_seq[i] > sq_seq);
    end
    rm_hit   = '0;
    rm_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!rm_found && rm_valid && surv_sq[i] &&
          ent_tid[i] == rm_tid && ent_seq[i] == rm_seq) begin
        rm_hit[i] = 1'b1;
        rm_found  = 1'b1;
      end
    end
    surv_rm   = surv_sq & ~rm_hit;
    pop_hit   = '0;
    head_seen = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!head_seen && surv_rm[i]) begin
        head_seen  = 1'b1;
        pop_hit[i] = pop_valid;
      end
    end
    keep = surv_rm & ~pop_hit;
    err  = (rm_valid && !rm_found) || (pop_valid && !head_seen);
  end
endmodule

// File: rtl/tagq_compact.sv
module tagq_compact #(
  parameter int DEPTH = 4,
  parameter int TID_W = 2,
  parameter int SEQ_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            keep,
  input  logic [DEPTH-1:0][TID_W-1:0] in_tid,
  input  logic [DEPTH-1:0][SEQ_W-1:0] in_seq,
  output logic [DEPTH-1:0][TID_W-1:0] out_tid,
  output logic [DEPTH-1:0][SEQ_W-1:0] out_seq,
  output logic [CNT_W-1:0]            kept_cnt
);
  always_comb begin
    out_tid  = '0;
    out_seq  = '0;
    kept_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        out_tid[kept_cnt[IDX_W-1:0]] = in_tid[i];
        out_seq[kept_cnt[IDX_W-1:0]] = in_seq[i];
        kept_cnt = kept_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tagq_bypass_buf.sv
module tagq_bypass_buf
  import tagq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int TID_W  = 2,
  parameter int SEQ_W  = 16,
  parameter int FREE_W = 3,
  parameter int BCNT_W = 16,
  localparam int NTHR  = 1 << TID_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_valid,
  input  logic [TID_W-1:0]  arr_tid,
  input  logic [NTHR-1:0]   fwd_blocked,
  input  logic [FREE_W-1:0] fwd_free,
  output logic              byp_go,
  output logic              byp_sched,
  output logic [1:0]        byp_why,
  output logic [BCNT_W-1:0] byp_count,
  input  logic              ins_valid,
  input  logic [TID_W-1:0]  ins_tid,
  input  logic [SEQ_W-1:0]  ins_seq,
  output logic              ins_done,
  output logic              ins_ok,
  input  logic              pop_valid,
  input  logic              rm_valid,
  input  logic [TID_W-1:0]  rm_tid,
  input  logic [SEQ_W-1:0]  rm_seq,
  input  logic              sq_valid,
  input  logic [TID_W-1:0]  sq_tid,
  input  logic [SEQ_W-1:0]  sq_seq,
  output logic              head_valid,
  output logic [TID_W-1:0]  head_tid,
  output logic [SEQ_W-1:0]  head_seq,
  output logic [CNT_W-1:0]  occupancy,
  output logic              err
);
  // stored state
  logic [DEPTH-1:0][TID_W-1:0] tid_q, tid_d, tid_c;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q, seq_d, seq_c;
  logic [CNT_W-1:0]            cnt_q, cnt_d, kept_cnt;
  logic [BCNT_W-1:0]           bcnt_q, bcnt_d;
  logic                        done_q, ok_q, err_q;
  logic                        ok_d, err_c;
  logic [DEPTH-1:0]            vld, keep;
  byp_why_e                    why;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) vld[i] = CNT_W'(i) < cnt_q;
  end

  tagq_bypass_judge #(.TID_W(TID_W), .FREE_W(FREE_W)) u_judge (
    .arr_valid   (arr_valid),
    .arr_tid     (arr_tid),
    .buf_empty   (cnt_q == '0),
    .fwd_blocked (fwd_blocked),
    .fwd_free    (fwd_free),
    .go          (byp_go),
    .sched       (byp_sched),
    .why         (why)
  );

  tagq_kill_mask #(.DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_kill (
    .ent_vld   (vld),
    .ent_tid   (tid_q),
    .ent_seq   (seq_q),
    .sq_valid  (sq_valid),
    .sq_tid    (sq_tid),
    .sq_seq    (sq_seq),
    .rm_valid  (rm_valid),
    .rm_tid    (rm_tid),
    .rm_seq    (rm_seq),
    .pop_valid (pop_valid),
    .keep      (keep),
    .err       (err_c)
  );

  tagq_compact #(.DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_pack (
    .keep     (keep),
    .in_tid   (tid_q),
    .in_seq   (seq_q),
    .out_tid  (tid_c),
    .out_seq  (seq_c),
    .kept_cnt (kept_cnt)
  );

  // next state: insert lands behind the compacted survivors
  always_comb begin
    tid_d  = tid_c;
    seq_d  = seq_c;
    cnt_d  = kept_cnt;
    ok_d   = 1'b0;
    if (ins_valid && kept_cnt < CNT_W'(DEPTH)) begin
      tid_d[kept_cnt[IDX_W-1:0]] = ins_tid;
      seq_d[kept_cnt[IDX_W-1:0]] = ins_seq;
      cnt_d = kept_cnt + 1'b1;
      ok_d  = 1'b1;
    end
    bcnt_d = bcnt_q + BCNT_W'(byp_go);
  end

  wire state_en = sq_valid | rm_valid | pop_valid | ins_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q  <= '0;
      seq_q  <= '0;
      cnt_q  <= '0;
      bcnt_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (state_en) begin
        tid_q <= tid_d;
        seq_q <= seq_d;
        cnt_q <= cnt_d;
      end
      if (byp_go) bcnt_q <= bcnt_d;
      done_q <= ins_valid;
      ok_q   <= ok_d;
      err_q  <= err_c;
    end
  end

  assign byp_why    = why;
  assign byp_count  = bcnt_q;
  assign ins_done   = done_q;
  assign ins_ok     = ok_q;
  assign err        = err_q;
  assign occupancy  = cnt_q;
  assign head_valid = cnt_q != '0;
  assign head_tid   = tid_q[0];
  assign head_seq   = seq_q[0];
endmodule

// File: rtl/tagq_bypass_buf_chk.sv
module tagq_bypass_buf_chk #(
  parameter int DEPTH  = 4,
  parameter int TID_W  = 2,
  parameter int SEQ_W  = 16,
  parameter int FREE_W = 3,
  parameter int BCNT_W = 16,
  localparam int NTHR  = 1 << TID_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arr_valid,
  input logic [TID_W-1:0]  arr_tid,
  input logic [NTHR-1:0]   fwd_blocked,
  input logic [FREE_W-1:0] fwd_free,
  input logic              byp_go,
  input logic              byp_sched,
  input logic [1:0]        byp_why,
  input logic [BCNT_W-1:0] byp_count,
  input logic              ins_valid,
  input logic              ins_done,
  input logic              ins_ok,
  input logic              pop_valid,
  input logic              rm_valid,
  input logic              sq_valid,
  input logic [TID_W-1:0]  head_tid,
  input logic [SEQ_W-1:0]  head_seq,
  input logic [CNT_W-1:0]  occupancy,
  input logic              err
);
  assert_bypass_conditions_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byp_go |-> (occupancy == '0 && !fwd_blocked[arr_tid] && fwd_free != '0));

  assert_refusal_has_reason_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byp_sched |-> byp_why != 2'd0);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byp_go |=> byp_count == $past(byp_count) + 1'b1);

  assert_full_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !sq_valid && !rm_valid && !pop_valid && occupancy == CNT_W'(DEPTH))
    |=> (ins_done && !ins_ok && occupancy == CNT_W'(DEPTH)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !pop_valid && !rm_valid && !sq_valid)
    |=> ($stable(occupancy) && $stable(head_tid) && $stable(head_seq)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  assert_pop_empty_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && occupancy == '0) |=> err);
endmodule

bind tagq_bypass_buf tagq_bypass_buf_chk #(
  .DEPTH(DEPTH), .TID_W(TID_W), .SEQ_W(SEQ_W), .FREE_W(FREE_W), .BCNT_W(BCNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_tid(arr_tid),
  .fwd_blocked(fwd_blocked), .fwd_free(fwd_free), .byp_go(byp_go),
  .byp_sched(byp_sched), .byp_why(byp_why), .byp_count(byp_count),
  .ins_valid(ins_valid), .ins_done(ins_done), .ins_ok(ins_ok),
  .pop_valid(pop_valid), .rm_valid(rm_valid), .sq_valid(sq_valid),
  .head_tid(head_tid), .head_seq(head_seq), .occupancy(occupancy), .err(err)
);

// File: tb/test_tagq_bypass_buf.sv
module test_tagq_bypass_buf;
  localparam int DEPTH = 4;
  localparam int TID_W = 2;
  localparam int SEQ_W = 16;
  localparam int FREE_W = 3;
  localparam int BCNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic arr_valid; logic [TID_W-1:0] arr_tid;
  logic [3:0] fwd_blocked; logic [FREE_W-1:0] fwd_free;
  logic byp_go, byp_sched; logic [1:0] byp_why; logic [BCNT_W-1:0] byp_count;
  logic ins_valid; logic [TID_W-1:0] ins_tid; logic [SEQ_W-1:0] ins_seq;
  logic ins_done, ins_ok, pop_valid;
  logic rm_valid; logic [TID_W-1:0] rm_tid; logic [SEQ_W-1:0] rm_seq;
  logic sq_valid; logic [TID_W-1:0] sq_tid; logic [SEQ_W-1:0] sq_seq;
  logic head_valid; logic [TID_W-1:0] head_tid; logic [SEQ_W-1:0] head_seq;
  logic [2:0] occupancy; logic err;

  always #10 clk = ~clk;  // 50 MHz

  tagq_bypass_buf i_tagq_bypass_buf (.*);

  int n_cmp = 0, n_bad = 0;
  logic [17:0] mq[$];            // {tid, seq}
  int m_bcnt = 0;
  bit m_done = 0, m_ok = 0, m_err = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    arr_valid = 0; arr_tid = 0; fwd_blocked = 0; fwd_free = 1;
    ins_valid = 0; ins_tid = 0; ins_seq = 0; pop_valid = 0;
    rm_valid = 0; rm_tid = 0; rm_seq = 0;
    sq_valid = 0; sq_tid = 0; sq_seq = 0;
  endtask

  task automatic check_regs();
    chk("R5", "occupancy", int'(occupancy), mq.size());
    chk("R5", "head_valid", int'(head_valid), int'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R8", "head_tid", int'(head_tid), int'(mq[0][17:16]));
      chk("R8", "head_seq", int'(head_seq), int'(mq[0][15:0]));
    end
    chk("R3", "byp_count", int'(byp_count), m_bcnt & 16'hFFFF);
    chk("R4", "ins_done", int'(ins_done), int'(m_done));
    chk("R4", "ins_ok", int'(ins_ok), int'(m_ok));
    chk("R10", "err", int'(err), int'(m_err));
  endtask

  task automatic tick();
    bit exp_go; int exp_why, idx;
    #1;
    exp_why = 0;
    if (arr_valid) begin
      if (mq.size() != 0) exp_why = 1;
      else if (fwd_blocked[arr_tid]) exp_why = 2;
      else if (fwd_free == 0) exp_why = 3;
    end
    exp_go = arr_valid && exp_why == 0;
    chk("R1", "byp_go", int'(byp_go), int'(exp_go));
    chk("R2", "byp_why", int'(byp_why), exp_why);
    chk("R2", "byp_sched", int'(byp_sched), int'(arr_valid && !exp_go));
    @(posedge clk);
    // reference: squash, remove, pop, insert (R9)
    m_err = 0;
    if (sq_valid) begin
      logic [17:0] keepq[$];
      foreach (mq[k])
        if (!(mq[k][17:16] == sq_tid && mq[k][15:0] > sq_seq)) keepq.push_back(mq[k]);
      mq = keepq;
    end
    if (rm_valid) begin
      idx = -1;
      foreach (mq[k]) if (idx < 0 && mq[k] == {rm_tid, rm_seq}) idx = k;
      if (idx < 0) m_err = 1; else mq.delete(idx);
    end
    if (pop_valid) begin
      if (mq.size() == 0) m_err = 1; else void'(mq.pop_front());
    end
    m_done = ins_valid;
    m_ok = ins_valid && mq.size() < DEPTH;
    if (m_ok) mq.push_back({ins_tid, ins_seq});
    if (exp_go) m_bcnt++;
    @(negedge clk);
    check_regs();
    idle();
  endtask

  task automatic put(int t, int s);
    idle(); ins_valid = 1; ins_tid = TID_W'(t); ins_seq = SEQ_W'(s); tick();
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk("R11", "occupancy", int'(occupancy), 0);
    chk("R11", "byp_count", int'(byp_count), 0);
    chk("R11", "ins_done", int'(ins_done), 0);
    chk("R11", "err", int'(err), 0);
    // R1/R3: bypass on empty queue, then each refusal cause
    idle(); arr_valid = 1; arr_tid = 1; fwd_free = 2; tick();
    idle(); arr_valid = 1; arr_tid = 2; fwd_blocked = 4'b0100; tick();
    idle(); arr_valid = 1; arr_tid = 3; fwd_free = 0; tick();
    idle(); arr_valid = 1; arr_tid = 2; fwd_blocked = 4'b0100; fwd_free = 0; tick();
    // R4/R5: fill and overflow
    put(0, 10); put(1, 20); put(0, 30); put(2, 40);
    idle(); arr_valid = 1; tick();                  // R2 nonempty
    put(3, 50);                                     // R4 rejected when full
    // R6/R8: remove from middle
    idle(); rm_valid = 1; rm_tid = 1; rm_seq = 20; tick();
    idle(); rm_valid = 1; rm_tid = 1; rm_seq = 20; tick(); // R10 no match
    // R9: squash with insert while full
    put(1, 60);
    idle(); sq_valid = 1; sq_tid = 0; sq_seq = 10; ins_valid = 1; ins_tid = 3; ins_seq = 70; tick();
    // R5: drain with pops, then pop empty (R10)
    repeat (4) begin idle(); pop_valid = 1; tick(); end
    idle(); pop_valid = 1; tick();
    // R7: boundary and large sequence numbers
    put(2, 16'hFFF0); put(2, 16'h0010); put(1, 16'hFFFF); put(2, 16'h0011);
    idle(); sq_valid = 1; sq_tid = 2; sq_seq = 16'h0010; tick();
    idle(); sq_valid = 1; sq_tid = 1; sq_seq = 16'hFFFE; pop_valid = 1; rm_valid = 1; rm_tid = 1; rm_seq = 16'hFFFF; tick();
    idle(); pop_valid = 1; tick();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      arr_valid   = ($urandom_range(0, 1) == 1);
      arr_tid     = TID_W'($urandom_range(0, 3));
      fwd_blocked = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      fwd_free    = FREE_W'($urandom_range(0, 2));
      ins_valid   = ($urandom_range(0, 9) < 6);
      ins_tid     = TID_W'($urandom_range(0, 3));
      ins_seq     = SEQ_W'($urandom_range(0, 7));
      pop_valid   = ($urandom_range(0, 9) < 2);
      rm_valid    = ($urandom_range(0, 9) < 2);
      rm_tid      = TID_W'($urandom_range(0, 3));
      rm_seq      = SEQ_W'($urandom_range(0, 7));
      sq_valid    = ($urandom_range(0, 9) < 1);
      sq_tid      = TID_W'($urandom_range(0, 3));
      sq_seq      = SEQ_W'($urandom_range(0, 7));
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule